// File: doc/BRIEF.md
# Lock-Gated Processor Reset Sequencer

This block drives a single open-drain line that does two jobs. It tells the system whether the clock generator is locked, and it gives the processor a timed reset. The line is modelled as a pull-low enable. A high on `pull_low` means the pin is driven low. A low on `pull_low` means the pin floats and an external resistor pulls it high. The clock generator, the resistor and the lock detector sit outside the block, and lock arrives as an input.

The line is held low whenever lock is missing. It is also held low while a reset request is active. After lock and an idle request have both been present for a fixed number of Q-clock cycles (`HOLD_CYCLES`, default 1024), the line is released. The request input is asynchronous to the Q clock and passes through a two-stage synchronizer. A saturating counter measures the hold window, and any disqualifying event sends it back to zero.

Top module: `lockrst_seq`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the counter is cleared and `pull_low` reads 1 after that edge. Both synchronizer stages reset to the "request active" value. After `rst_n` returns high, with `lock_ok` high and `req_n` high, `pull_low` first reads 0 after the (HOLD_CYCLES+2)-th rising edge.
- R2: Whenever `lock_ok` is 0, `pull_low` is 1 within the same cycle, without waiting for a clock edge, whatever the counter holds.
- R3: With the synchronized request idle and `lock_ok` high, the counter advances by one per rising edge. `pull_low` becomes 0 after exactly HOLD_CYCLES such consecutive edges. `pull_low` = 1 means drive the pin low, and 0 means high impedance.
- R4: A drop of `lock_ok` clears the count. When lock returns, a full HOLD_CYCLES qualifying edges are needed again before release.
- R5: `req_n` low at a rising edge (active-low request) makes `pull_low` read 1 no later than after the third rising edge that follows: two synchronizer stages, then the counter clear.
- R6: After `req_n` returns high, `pull_low` first reads 0 after the (HOLD_CYCLES+2)-th rising edge, counted from the first edge that samples `req_n` high. A request pulse one cycle wide is enough to start the full sequence.
- R7: A request that arrives while a count is in progress discards the partial count. The next release again takes HOLD_CYCLES+2 edges from the end of the request.
- R8: Once released, the counter saturates at HOLD_CYCLES and never exceeds it. `pull_low` stays 0 for as long as lock holds and no request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_q | input | 1 | Q-rate clock that times the hold window |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| req_n | input | 1 | Asynchronous active-low reset request |
| lock_ok | input | 1 | Lock flag from the clock generator, high when locked |
| pull_low | output | 1 | Open-drain enable: 1 drives the pin low, 0 leaves it floating |

## Verification
The bench runs with a 16-cycle hold window and sweeps the point at which lock drops, across every partial count from 1 to one short of terminal. This shows whether a lock loss really restarts the window or only pauses it. It sweeps request pulses of widths 1 to 4 applied to a released line and to partial counts of 0, 3 and one short of terminal. The last case catches a release that slips through while the synchronizer is still delivering the request. Every cycle of every sweep is compared against an edge-count formula. A long dwell after release checks that the saturated state holds.

// File: rtl/lockrst_pkg.sv
// Package: lockrst_pkg
// Shared constants and helpers for the lock-gated reset sequencer.
// Assumes the hold window is at least 4 cycles long.
package lockrst_pkg;

    // Default number of Q cycles the line is held after lock or request end.
    localparam int unsigned DEFAULT_HOLD = 1024;

    // Counter width able to hold the terminal value itself.
    function automatic int unsigned hold_width(input int unsigned hold);
        return $clog2(hold + 1);
    endfunction

    // Reset value of the synchronizer stages: treat the request as active.
    localparam logic REQ_ACTIVE_LVL = 1'b0;

endpackage

// File: rtl/lockrst_req_sync.sv
// Module: lockrst_req_sync
// Brings the asynchronous active-low request into the Q-clock domain
// through a chain of STAGES flops. Reset loads the "request active" level,
// so the sequencer never sees an idle request before the chain is filled.
// Assumes STAGES >= 2.
module lockrst_req_sync
    import lockrst_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_req_n,
    output logic req_idle
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw request through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{REQ_ACTIVE_LVL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_req_n};
        end
    end

    assign req_idle = chain_q[STAGES-1];

endmodule

// File: rtl/lockrst_hold_counter.sv
// Module: lockrst_hold_counter
// Saturating up-counter that measures the hold window. It counts while
// `run` is high, clears at once on any cycle where `run` is low, and
// stops at HOLD. `done` flags the terminal value.
module lockrst_hold_counter
    import lockrst_pkg::*;
#(
    parameter int unsigned HOLD  = DEFAULT_HOLD,
    localparam int unsigned CNT_W = hold_width(HOLD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] count,
    output logic             done
);

    localparam logic [CNT_W-1:0] TERM = CNT_W'(HOLD);

    logic [CNT_W-1:0] cnt_q;

    // Advance, clear or hold the window count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != TERM) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign count = cnt_q;
    assign done  = (cnt_q == TERM);

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0)); // R4
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_q != TERM) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R3
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && done) |=> done); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TERM); // R8

endmodule

// File: rtl/lockrst_release_ctrl.sv
// Module: lockrst_release_ctrl
// Decides the open-drain enable. The lock flag bypasses every register,
// so a loss of lock pulls the line low in the same cycle. Release needs
// both lock and a completed hold window.
module lockrst_release_ctrl (
    input  logic lock_ok,
    input  logic window_done,
    output logic pull_low
);

    // Keep the line low unless locked and the window has completed.
    always_comb begin
        pull_low = 1'b1;
        if (lock_ok && window_done) begin
            pull_low = 1'b0;
        end
    end

endmodule

// File: rtl/lockrst_seq.sv
// Module: lockrst_seq (top)
// Lock-gated processor reset sequencer. It drives an open-drain reset and
// lock line through `pull_low`. The line stays low until lock has been
// present, with no request, for HOLD_CYCLES Q cycles. Assumes `lock_ok`
// is already synchronous to clk_q and `req_n` may be asynchronous.
module lockrst_seq
    import lockrst_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = DEFAULT_HOLD,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned CNT_W      = hold_width(HOLD_CYCLES)
) (
    input  logic clk_q,
    input  logic rst_n,
    input  logic req_n,
    input  logic lock_ok,
    output logic pull_low
);

    logic             req_idle;
    logic             run;
    logic             window_done;
    logic [CNT_W-1:0] window_cnt;

    lockrst_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk_q),
        .rst_n       (rst_n),
        .async_req_n (req_n),
        .req_idle    (req_idle)
    );

    // The window runs only while locked and with no request pending.
    assign run = lock_ok & req_idle;

    lockrst_hold_counter #(.HOLD(HOLD_CYCLES)) u_cnt (
        .clk   (clk_q),
        .rst_n (rst_n),
        .run   (run),
        .count (window_cnt),
        .done  (window_done)
    );

    lockrst_release_ctrl u_rel (
        .lock_ok     (lock_ok),
        .window_done (window_done),
        .pull_low    (pull_low)
    );

    AST_POR_LOW: assert property (@(posedge clk_q)
        $rose(rst_n) |-> pull_low); // R1
    AST_RELEASE_NEEDS_LOCK: assert property (@(posedge clk_q) disable iff (!rst_n)
        !pull_low |-> lock_ok); // R2
    AST_REQ_FORCES_LOW: assert property (@(posedge clk_q) disable iff (!rst_n)
        ($past(req_n, 3) == 1'b0) |-> pull_low); // R5
    AST_RELEASE_AT_TERM: assert property (@(posedge clk_q) disable iff (!rst_n)
        $fell(pull_low) |-> (window_cnt == CNT_W'(HOLD_CYCLES))); // R3

endmodule

// File: tb/sim_lockrst_seq.sv
module sim_lockrst_seq;

    localparam int H = 16;

    logic clk_q = 1'b0;
    logic rst_n = 1'b0;
    logic req_n = 1'b1;
    logic lock_ok = 1'b0;
    logic pull_low;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk_q = ~clk_q;

    lockrst_seq #(.HOLD_CYCLES(H)) u0 (
        .clk_q    (clk_q),
        .rst_n    (rst_n),
        .req_n    (req_n),
        .lock_ok  (lock_ok),
        .pull_low (pull_low)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: pull_low=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk_q);
        @(negedge clk_q);
    endtask

    // Count n edges. The line is released when the count reaches H, with
    // the count equal to j - lag after edge j.
    task automatic run_window(input int lag, input string req);
        for (int j = 1; j <= H + lag; j++) begin
            step();
            check(pull_low, (j - lag) < H, req);
        end
    endtask

    // Start from a fresh partial count k (k == H means released).
    task automatic to_count(input int k);
        if (k < H) begin
            lock_ok = 1'b0;
            step();
            lock_ok = 1'b1;
            for (int i = 0; i < k; i++) step();
        end
    endtask

    // Expected line after absolute edge a of a request pulse of width w
    // applied at count k.
    function automatic logic exp_req(input int k, input int w, input int a);
        int j;
        j = a - w;
        if (a <= 2) return (k + a) < H;
        if (j <= 2) return 1'b1;
        return (j - 2) < H;
    endfunction

    initial begin
        #(200000 * 20);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int kset[4];
        kset = '{H, 0, 3, H - 1};

        // R1: reset state, then release timed from reset deassertion.
        @(negedge clk_q);
        repeat (3) step();
        check(pull_low, 1'b1, "R1");
        rst_n = 1'b1;
        lock_ok = 1'b1;
        run_window(2, "R1");

        // R8: released state is stable over a long dwell.
        for (int i = 0; i < 3 * H; i++) begin
            step();
            check(pull_low, 1'b0, "R8");
        end

        // R2: loss of lock pulls the line low in the same cycle.
        lock_ok = 1'b0;
        #1 check(pull_low, 1'b1, "R2");
        step();
        check(pull_low, 1'b1, "R2");
        lock_ok = 1'b1;
        run_window(0, "R3");

        // R4: lock drop at every partial count restarts the window.
        for (int k = 1; k < H; k++) begin
            lock_ok = 1'b0;
            step();
            lock_ok = 1'b1;
            for (int i = 0; i < k; i++) begin
                step();
                check(pull_low, 1'b1, "R4");
            end
            lock_ok = 1'b0;
            #1 check(pull_low, 1'b1, "R2");
            step();
            lock_ok = 1'b1;
            run_window(0, "R4");
        end

        // R5, R6, R7: request pulses of several widths at several counts.
        for (int w = 1; w <= 4; w++) begin
            foreach (kset[n]) begin
                int k;
                k = kset[n];
                to_count(k);
                req_n = 1'b0;
                for (int a = 1; a <= w; a++) begin
                    step();
                    check(pull_low, exp_req(k, w, a), "R5");
                end
                req_n = 1'b1;
                for (int a = w + 1; a <= w + H + 2; a++) begin
                    step();
                    check(pull_low, exp_req(k, w, a), (k < H) ? "R7" : "R6");
                end
            end
        end

        // R1: power-on reset mid-operation pulls low and restarts.
        rst_n = 1'b0;
        step();
        check(pull_low, 1'b1, "R1");
        rst_n = 1'b1;
        run_window(2, "R1");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule